// File: doc/BRIEF.md
# Long-Mode Segment Register Load Checker

This block decides whether a segment register load is allowed when the processor runs in 64-bit mode. A request carries the 16-bit selector, the register class being loaded (code, data or stack), the current privilege level, and the 8-byte descriptor that has already been fetched from the descriptor table. The block splits the selector into its index, table and requested-privilege fields and decodes the descriptor's access and flag bits. It then applies the long-mode rules and reports either an accept or one fault code. An accepted code load also reports the operand width of the new code segment.

Base and limit fields have no effect in this mode, so the block does not read them. Fetching the descriptor is left to the surrounding logic. The decision is made by one level of combinational logic and registered once, so each request gets its response on the following clock edge.

Top module: `seg_load_checker`

## Requirements
- R1: The selector holds the index in bits [15:3], the table bit in bit 2 and the requested privilege (RPL) in bits [1:0]. A selector is null when the index is 0 and the table bit is 0. A null selector loaded into the code or stack class faults with code 1 (null). A null selector loaded into the data class is accepted, and the descriptor is not examined.
- R2: The descriptor fields are taken from these bit positions: type [43:40], S bit 44, DPL [46:45], P bit 47, L bit 53, D bit 54. Changing any other descriptor bit (base, limit, granularity, spare bits) does not change the response.
- R3: Target code 1 (code class) needs S=1 and type bit 3 set, otherwise fault 2 (type). A nonconforming segment (type bit 2 clear) needs DPL equal to CPL. A conforming segment needs DPL no greater than CPL. A failed privilege test gives fault 3 (privilege).
- R4: Target code 0 (data class) needs S=1 and either type bit 3 clear or type bit 1 (readable) set, otherwise fault 2. Data segments and nonconforming code segments need DPL to be at least the larger of CPL and RPL, otherwise fault 3. A conforming readable code segment skips the privilege test.
- R5: Target code 2 (stack class) needs S=1, type bit 3 clear and type bit 1 (writable) set, otherwise fault 2. It also needs RPL equal to CPL and DPL equal to CPL, otherwise fault 3.
- R6: A load that passes the type and privilege tests but has P=0 faults with code 4 (not present).
- R7: A code-class load that passes every other test but has L=1 and D=1 faults with code 5 (bad L/D pair).
- R8: The width output is 3 for an accepted code load with L=1, 2 for one with L=0 and D=1, and 1 for one with L=0 and D=0. It is 0 in every other case.
- R9: Faults are ranked in this order: target code 3 (reserved, fault 2), then null, then type, then privilege, then not present, then bad L/D. The accept output is 1 exactly when the fault output is 0.
- R10: The response appears on the clock edge after the request, and rsp_valid repeats req_valid one cycle later. A synchronous active-low reset clears all response outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A load request is present this cycle |
| req_sel | input | 16 | Selector being loaded |
| req_target | input | 2 | Register class: 0 data, 1 code, 2 stack, 3 reserved |
| req_cpl | input | 2 | Current privilege level |
| req_desc | input | 64 | Descriptor fetched for the selector |
| rsp_valid | output | 1 | Response is present |
| rsp_accept | output | 1 | Load is allowed |
| rsp_width | output | 2 | Code width: 0 none, 1 16-bit, 2 32-bit, 3 64-bit |
| rsp_fault | output | 3 | 0 none, 1 null, 2 type, 3 privilege, 4 not present, 5 bad L/D |

## Verification
The bench targets the points where the rule ranking matters. A null selector with a garbage descriptor must be accepted for data but faulted for code and stack; a design that checks the descriptor first would report a type or not-present fault instead. It targets loads that are both not present and of the wrong privilege, and 64-bit code with D set that is also of the wrong privilege, since a wrong ranking reports the wrong code there. It also covers conforming code seen from both the code and data classes, a stack selector whose RPL differs from CPL, and a descriptor with its base and limit bits flipped, which a design that decoded the wrong bit positions would judge differently.

// File: rtl/seg_chk_pkg.sv
// Package: shared encodings and field positions for the segment load checker.
// Assumes an 8-byte descriptor and a 16-bit selector. Field positions are
// fixed because the descriptor table format is decoded by other logic.
package seg_chk_pkg;
    localparam int SEL_W   = 16;
    localparam int DESC_W  = 64;
    localparam int PL_W    = 2;
    localparam int IDX_LSB = 3;
    localparam int TI_BIT  = 2;

    localparam int TYPE_LSB = 40;
    localparam int S_BIT    = 44;
    localparam int DPL_LSB  = 45;
    localparam int P_BIT    = 47;
    localparam int L_BIT    = 53;
    localparam int D_BIT    = 54;

    typedef enum logic [1:0] {
        TGT_DATA  = 2'd0,
        TGT_CODE  = 2'd1,
        TGT_STACK = 2'd2,
        TGT_RSVD  = 2'd3
    } tgt_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_NULL  = 3'd1,
        FLT_TYPE  = 3'd2,
        FLT_PRIV  = 3'd3,
        FLT_NOTP  = 3'd4,
        FLT_BADLD = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        WID_NONE = 2'd0,
        WID_16   = 2'd1,
        WID_32   = 2'd2,
        WID_64   = 2'd3
    } width_e;

    typedef struct packed {
        logic [3:0]      seg_type;
        logic            s;
        logic [PL_W-1:0] dpl;
        logic            p;
        logic            l;
        logic            d;
        logic            is_code;
        logic            conform;
        logic            rw;
    } desc_f_t;
endpackage

// File: rtl/seg_sel_split.sv
// Module: splits a selector into its fields and flags the null selector.
// Assumes the index sits above the table bit, with RPL in the lowest bits.
module seg_sel_split
    import seg_chk_pkg::*;
#(
    parameter int W = SEL_W
) (
    input  logic [W-1:0]    sel,
    output logic [PL_W-1:0] rpl,
    output logic            ti,
    output logic            is_null
);
    localparam int IDX_W = W - IDX_LSB;

    logic [IDX_W-1:0] index;

    // Field extraction and null detection (index 0 in the global table).
    always_comb begin
        index   = sel[W-1:IDX_LSB];
        ti      = sel[TI_BIT];
        rpl     = sel[PL_W-1:0];
        is_null = (index == '0) && !ti;
    end
endmodule

// File: rtl/seg_desc_decode.sv
// Module: decodes the access byte and flags of an 8-byte descriptor.
// Assumes base, limit, granularity and spare bits carry no meaning in
// 64-bit mode; they are gathered into one unused signal.
module seg_desc_decode
    import seg_chk_pkg::*;
#(
    parameter int W = DESC_W
) (
    input  logic [W-1:0] desc,
    output desc_f_t      f
);
    logic unused_desc_bits;

    // Pick out the fields that the long-mode rules depend on.
    always_comb begin
        f.seg_type = desc[TYPE_LSB +: 4];
        f.s        = desc[S_BIT];
        f.dpl      = desc[DPL_LSB +: PL_W];
        f.p        = desc[P_BIT];
        f.l        = desc[L_BIT];
        f.d        = desc[D_BIT];
        f.is_code  = desc[TYPE_LSB + 3];
        f.conform  = desc[TYPE_LSB + 3] & desc[TYPE_LSB + 2];
        f.rw       = desc[TYPE_LSB + 1];
    end

    // Fold the fields that are ignored in this mode.
    assign unused_desc_bits = ^{desc[TYPE_LSB-1:0], desc[L_BIT-1:P_BIT+1], desc[W-1:D_BIT+1]};
endmodule

// File: rtl/seg_rule_eval.sv
// Module: applies the per-class type and privilege rules in one
// combinational step. Assumes fields are already decoded; produces
// individual verdicts that the top ranks into one fault code.
module seg_rule_eval
    import seg_chk_pkg::*;
(
    input  logic [1:0]      target,
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] rpl,
    input  logic            is_null,
    input  desc_f_t         f,
    output logic            rsvd_tgt,
    output logic            null_flt,
    output logic            null_ok,
    output logic            type_ok,
    output logic            priv_ok,
    output logic            ld_bad,
    output logic [1:0]      code_width
);
    logic [PL_W-1:0] eff_pl;

    // Effective privilege for data loads: the weaker of CPL and RPL.
    always_comb eff_pl = (cpl > rpl) ? cpl : rpl;

    // Class-specific verdicts.
    always_comb begin
        rsvd_tgt   = 1'b0;
        null_flt   = 1'b0;
        null_ok    = 1'b0;
        type_ok    = 1'b0;
        priv_ok    = 1'b0;
        ld_bad     = 1'b0;
        code_width = WID_NONE;
        unique case (tgt_e'(target))
            TGT_DATA: begin
                null_ok = is_null;
                type_ok = f.s && (!f.is_code || f.rw);
                priv_ok = f.conform || (f.dpl >= eff_pl);
            end
            TGT_CODE: begin
                null_flt = is_null;
                type_ok  = f.s && f.is_code;
                priv_ok  = f.conform ? (f.dpl <= cpl) : (f.dpl == cpl);
                ld_bad   = f.l && f.d;
                if (f.l)      code_width = WID_64;
                else if (f.d) code_width = WID_32;
                else          code_width = WID_16;
            end
            TGT_STACK: begin
                null_flt = is_null;
                type_ok  = f.s && !f.is_code && f.rw;
                priv_ok  = (rpl == cpl) && (f.dpl == cpl);
            end
            default: rsvd_tgt = 1'b1;
        endcase
    end
endmodule

// File: rtl/seg_load_checker.sv
// Module: top of the long-mode segment load checker. Ranks the rule
// verdicts into one fault code and registers the response one cycle after
// the request. Assumes the descriptor arrives with the request.
module seg_load_checker
    import seg_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [1:0]        req_target,
    input  logic [PL_W-1:0]   req_cpl,
    input  logic [DESC_W-1:0] req_desc,
    output logic              rsp_valid,
    output logic              rsp_accept,
    output logic [1:0]        rsp_width,
    output logic [2:0]        rsp_fault
);
    logic [PL_W-1:0] rpl;
    logic            ti;
    logic            is_null;
    desc_f_t         f;
    logic            rsvd_tgt, null_flt, null_ok, type_ok, priv_ok, ld_bad;
    logic [1:0]      code_width;
    fault_e          fault_d;
    logic            accept_d;
    logic            unused_ti;

    seg_sel_split #(.W(SEL_W)) sel_i (
        .sel(req_sel), .rpl(rpl), .ti(ti), .is_null(is_null)
    );

    seg_desc_decode #(.W(DESC_W)) dec_i (
        .desc(req_desc), .f(f)
    );

    seg_rule_eval rule_i (
        .target(req_target), .cpl(req_cpl), .rpl(rpl), .is_null(is_null),
        .f(f), .rsvd_tgt(rsvd_tgt), .null_flt(null_flt), .null_ok(null_ok),
        .type_ok(type_ok), .priv_ok(priv_ok), .ld_bad(ld_bad),
        .code_width(code_width)
    );

    assign unused_ti = ti;

    // Rank the verdicts into a single fault code.
    always_comb begin
        accept_d = 1'b0;
        if (rsvd_tgt)      fault_d = FLT_TYPE;
        else if (null_flt) fault_d = FLT_NULL;
        else if (null_ok)  begin fault_d = FLT_NONE; accept_d = 1'b1; end
        else if (!type_ok) fault_d = FLT_TYPE;
        else if (!priv_ok) fault_d = FLT_PRIV;
        else if (!f.p)     fault_d = FLT_NOTP;
        else if (ld_bad)   fault_d = FLT_BADLD;
        else begin fault_d = FLT_NONE; accept_d = 1'b1; end
    end

    // Register the response; reset clears every output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_accept <= 1'b0;
            rsp_width  <= WID_NONE;
            rsp_fault  <= FLT_NONE;
        end else begin
            rsp_valid  <= req_valid;
            rsp_accept <= req_valid && accept_d;
            rsp_width  <= (req_valid && accept_d && !null_ok) ? code_width : WID_NONE;
            rsp_fault  <= req_valid ? fault_d : FLT_NONE;
        end
    end

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_accept_nofault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_accept == (rsp_fault == 3'd0)));
    assert_null_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_target == 2'd1 && req_sel[SEL_W-1:2] == '0) |=> rsp_fault == 3'd1);
    assert_stack_rpl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_target == 2'd2 && req_sel[1:0] != req_cpl) |=> !rsp_accept);
    assert_notp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_desc[P_BIT] && !(req_target == 2'd0 && req_sel[SEL_W-1:2] == '0))
        |=> !rsp_accept);
    assert_ld_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_target == 2'd1 && req_desc[L_BIT] && req_desc[D_BIT]) |=> !rsp_accept);
    assert_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_width != 2'd0) |-> rsp_accept);
endmodule

// File: tb/seg_load_checker_tb_top.sv
`timescale 1ns/1ps
module seg_load_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_sel = '0;
    logic [1:0]  req_target = '0;
    logic [1:0]  req_cpl = '0;
    logic [63:0] req_desc = '0;
    logic        rsp_valid, rsp_accept;
    logic [1:0]  rsp_width;
    logic [2:0]  rsp_fault;
    int          n_checks = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    seg_load_checker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_target(req_target), .req_cpl(req_cpl), .req_desc(req_desc),
        .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
        .rsp_width(rsp_width), .rsp_fault(rsp_fault)
    );

    function automatic logic [63:0] mk_desc(input logic [3:0] ty, input logic s,
            input logic [1:0] dpl, input logic p, input logic l, input logic d);
        logic [63:0] v = '0;
        v[43:40] = ty; v[44] = s; v[46:45] = dpl; v[47] = p; v[53] = l; v[54] = d;
        return v;
    endfunction

    // Expected {accept, width, fault} from the requirement text.
    function automatic logic [5:0] model(input logic [15:0] sel, input logic [1:0] tgt,
            input logic [1:0] cpl, input logic [63:0] ds);
        logic [1:0] rpl = sel[1:0];
        logic nul = (sel[15:3] == 0) && !sel[2];
        logic [3:0] ty = ds[43:40];
        logic s = ds[44]; logic [1:0] dpl = ds[46:45]; logic p = ds[47];
        logic l = ds[53]; logic d = ds[54];
        logic tok, pok;
        logic [1:0] mx = (cpl > rpl) ? cpl : rpl;
        logic [1:0] w = 2'd0;
        if (tgt == 2'd3) return {1'b0, 2'd0, 3'd2};                 // R9
        if (nul && tgt != 2'd0) return {1'b0, 2'd0, 3'd1};          // R1
        if (nul) return {1'b1, 2'd0, 3'd0};                         // R1
        case (tgt)
            2'd0: begin tok = s && (!ty[3] || ty[1]);                // R4
                  pok = (ty[3] && ty[2]) || (dpl >= mx); end
            2'd1: begin tok = s && ty[3];                            // R3
                  pok = ty[2] ? (dpl <= cpl) : (dpl == cpl);
                  w = l ? 2'd3 : (d ? 2'd2 : 2'd1); end              // R8
            default: begin tok = s && !ty[3] && ty[1];               // R5
                  pok = (rpl == cpl) && (dpl == cpl); end
        endcase
        if (!tok) return {1'b0, 2'd0, 3'd2};
        if (!pok) return {1'b0, 2'd0, 3'd3};
        if (!p) return {1'b0, 2'd0, 3'd4};                           // R6
        if (tgt == 2'd1 && l && d) return {1'b0, 2'd0, 3'd5};        // R7
        return {1'b1, w, 3'd0};
    endfunction

    task automatic check(input string tag, input logic [15:0] sel, input logic [1:0] tgt,
            input logic [1:0] cpl, input logic [63:0] ds);
        logic [5:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_target = tgt; req_cpl = cpl; req_desc = ds;
        exp = model(sel, tgt, cpl, ds);
        @(negedge clk);
        n_checks++;
        if (!rsp_valid || {rsp_accept, rsp_width, rsp_fault} != exp) begin
            n_fail++;
            $display("FAIL %s: got v=%0b acc=%0b wid=%0d flt=%0d, expected v=1 acc=%0b wid=%0d flt=%0d",
                     tag, rsp_valid, rsp_accept, rsp_width, rsp_fault, exp[5], exp[4:3], exp[2:0]);
        end
    endtask

    task automatic expect_val(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] kcode, ucode, kdata, udata;
        void'($urandom(32'd1234));
        kcode = mk_desc(4'hA, 1, 0, 1, 1, 0) | 64'h000F_0000_0000_FFFF;
        ucode = mk_desc(4'hA, 1, 3, 1, 1, 0);
        kdata = mk_desc(4'h2, 1, 0, 1, 0, 1);
        udata = mk_desc(4'h2, 1, 3, 1, 0, 1);
        // Reset with a live request: outputs must stay clear (R10).
        req_valid = 1'b1; req_sel = 16'h0008; req_target = 2'd1; req_desc = kcode;
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_val("R10 reset valid", rsp_valid, 0);
        expect_val("R10 reset accept", rsp_accept, 0);
        expect_val("R10 reset fault", rsp_fault, 0);
        rst_n = 1'b1;

        check("R3 R8 kernel 64-bit code", 16'h0008, 2'd1, 2'd0, kcode);
        check("R3 R8 user code 0x1B", 16'h001B, 2'd1, 2'd3, ucode);
        check("R3 code dpl mismatch", 16'h0008, 2'd1, 2'd3, kcode);
        check("R3 conforming from ring3", 16'h0010, 2'd1, 2'd3, mk_desc(4'hE, 1, 1, 1, 1, 0));
        check("R8 32-bit code", 16'h0030, 2'd1, 2'd0, mk_desc(4'hA, 1, 0, 1, 0, 1));
        check("R8 16-bit code", 16'h0030, 2'd1, 2'd0, mk_desc(4'hA, 1, 0, 1, 0, 0));
        check("R7 L and D both set", 16'h0008, 2'd1, 2'd0, mk_desc(4'hA, 1, 0, 1, 1, 1));
        check("R9 L/D below priv", 16'h0008, 2'd1, 2'd3, mk_desc(4'hA, 1, 0, 1, 1, 1));
        check("R1 null into data", 16'h0003, 2'd0, 2'd3, 64'h0);
        check("R1 null into code", 16'h0000, 2'd1, 2'd0, kcode);
        check("R1 null into stack", 16'h0002, 2'd2, 2'd2, kdata);
        check("R1 index0 local table", 16'h0004, 2'd0, 2'd0, kdata);
        check("R2 system TSS type", 16'h0028, 2'd0, 2'd0, mk_desc(4'h9, 0, 0, 1, 0, 0));
        check("R2 base/limit flipped", 16'h0010, 2'd0, 2'd0, kdata | 64'hFF8F_00FF_FFFF_FFFF);
        check("R4 data rpl raises level", 16'h0013, 2'd0, 2'd0, kdata);
        check("R4 user data ring3", 16'h0023, 2'd0, 2'd3, udata);
        check("R4 exec-only code", 16'h0008, 2'd0, 2'd0, mk_desc(4'h8, 1, 0, 1, 1, 0));
        check("R4 conforming readable", 16'h000B, 2'd0, 2'd3, mk_desc(4'hE, 1, 0, 1, 1, 0));
        check("R5 stack ok", 16'h0010, 2'd2, 2'd0, kdata);
        check("R5 stack rpl mismatch", 16'h0013, 2'd2, 2'd0, kdata);
        check("R5 stack read-only", 16'h0010, 2'd2, 2'd0, mk_desc(4'h0, 1, 0, 1, 0, 1));
        check("R6 not present", 16'h0010, 2'd0, 2'd0, mk_desc(4'h2, 1, 0, 0, 0, 1));
        check("R9 priv above not present", 16'h0010, 2'd0, 2'd3, mk_desc(4'h2, 1, 0, 0, 0, 1));
        check("R9 reserved target", 16'h0000, 2'd3, 2'd0, kcode);

        for (int i = 0; i < 3000; i++) begin
            logic [15:0] sel = 16'($urandom);
            logic [63:0] ds = {32'($urandom), 32'($urandom)};
            if ($urandom_range(7) == 0) sel[15:2] = '0;
            if ($urandom_range(3) != 0) ds[44] = 1'b1;
            if ($urandom_range(3) != 0) ds[47] = 1'b1;
            check("R9 random", sel, 2'($urandom), 2'($urandom), ds);
        end

        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        expect_val("R10 idle drops valid", rsp_valid, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule